// File: doc/BRIEF.md
# Preloaded Error-Event Trigger Counters

This block keeps two independent error-event counters for a receive datapath. Counter 0 counts one class of timing error of the multicarrier demodulator, counter 1 counts one class of timing error of the single-carrier demodulator. Which event codes each counter accepts is set by a per-counter event mask, where bit *n* of the mask enables event code *n*.

Rather than comparing against a threshold, each counter is preloaded with a base equal to a fixed ceiling minus a programmed trigger level. With the default ceiling of `0xC000_0000`, the two most significant bits of the counter both become 1 exactly when the trigger count has been reached, and the block then raises a level interrupt. Software reads raw and net counts without disturbing them. It issues a restart to reload the bases and masks and to clear the interrupt. Dropping the enable input stops all counting until the next restart.

Top module: `phyerr_trig_cnt`

## Requirements
- R1: On reset and on restart each counter is loaded with its base, which is COUNTMAX minus its trigger level, or 0 when the trigger level is COUNTMAX or more. The reset trigger levels are 500 for counter 0 and 200 for counter 1.
- R2: An event strobe with code t adds one to a counter only when bit t of that counter's active mask is 1. The reset masks enable only code 17 for counter 0 and only code 25 for counter 1.
- R3: A counter stops at all-ones and never wraps.
- R4: `irq` goes to 1 on the cycle after either counter has both of its two most significant bits set. It stays at 1 until a restart, and a restart forces it to 0 on the following cycle.
- R5: A read request is answered by `rd_ack` one cycle later. `rd_raw` holds the counter value from before any event in the same cycle, and reading never changes a counter.
- R6: `rd_net` is the raw value minus the current base. When the raw value is below that base, `rd_net` reports COUNTMAX instead.
- R7: `rd_delta` is the net value minus the net value returned by the previous read of the same counter. A restart sets both stored previous values to 0, and it wins over a read in the same cycle.
- R8: A restart reloads both counters from the current bases and copies the programmed masks into the active masks. A restart takes priority over an event in the same cycle, and that event is lost.
- R9: While `count_en` is 0 no event is counted, and both active masks are cleared. Counting therefore stays off after `count_en` returns to 1, until the next restart.
- R10: Configuration writes use address 0 for the counter-0 trigger, 1 for the counter-1 trigger, 2 for the counter-0 mask and 3 for the counter-1 mask. A new trigger changes the base used by `rd_net` on the next cycle. Counters and active masks take new values only at a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Configuration write strobe |
| wr_addr | input | 2 | Configuration register select |
| wr_data | input | CNT_W | Trigger level or event mask |
| restart | input | 1 | Reload bases and masks, clear interrupt and previous net values |
| count_en | input | 1 | Counting enable; low clears the active masks |
| ev_valid | input | 1 | Error event strobe |
| ev_type | input | TYPE_W | Error event code |
| rd_valid | input | 1 | Read request |
| rd_sel | input | 1 | Counter to read (0 or 1) |
| rd_ack | output | 1 | Read data valid |
| rd_raw | output | CNT_W | Raw counter value |
| rd_net | output | CNT_W | Raw value minus base, or COUNTMAX if negative |
| rd_delta | output | CNT_W | Net value minus the previous net value read |
| irq | output | 1 | Sticky trigger interrupt |

## Verification
The assertions assume that `rst` is held for at least one clock edge before checking starts, and that at most one event arrives per cycle. That single event is a given of the interface, not something the checker enforces. The stimulus drives every input on the falling edge, so each event, write, read and restart is seen at exactly one rising edge. Trigger levels in the random phase are kept mostly small so that the interrupt, saturation and negative-net paths are reached many times, and a few directed writes use levels at or above COUNTMAX.

// File: rtl/phyerr_trig_pkg.sv
package phyerr_trig_pkg;

  localparam int NUM_CNT = 2;
  localparam int IDX_MC  = 0;  // multicarrier timing errors
  localparam int IDX_SC  = 1;  // single-carrier timing errors

  typedef enum logic [1:0] {
    CFG_MC_TRIG = 2'd0,
    CFG_SC_TRIG = 2'd1,
    CFG_MC_MASK = 2'd2,
    CFG_SC_MASK = 2'd3
  } cfg_addr_e;

  // Preload value: ceiling minus trigger, floored at zero.
  function automatic logic [63:0] base_calc(input logic [63:0] trig,
                                            input logic [63:0] ceil);
    return (trig >= ceil) ? 64'd0 : (ceil - trig);
  endfunction

endpackage

// File: rtl/ptc_cfg_regs.sv
module ptc_cfg_regs
  import phyerr_trig_pkg::*;
#(
  parameter int                            CNT_W     = 32,
  parameter int                            NUM_TYPES = 32,
  parameter logic [CNT_W-1:0]              COUNTMAX  = 32'hC000_0000,
  parameter logic [NUM_CNT-1:0][CNT_W-1:0] RST_BASE  = '0,
  parameter logic [NUM_CNT-1:0][NUM_TYPES-1:0] RST_MASK = '0
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_valid,
  input  logic [1:0]                          wr_addr,
  input  logic [CNT_W-1:0]                    wr_data,
  output logic [NUM_CNT-1:0][CNT_W-1:0]       base_o,
  output logic [NUM_CNT-1:0][NUM_TYPES-1:0]   mask_o
);

  logic [CNT_W-1:0] new_base;

  assign new_base = CNT_W'(base_calc(64'(wr_data), 64'(COUNTMAX)));

  always_ff @(posedge clk) begin
    if (rst) begin
      base_o <= RST_BASE;
      mask_o <= RST_MASK;
    end else if (wr_valid) begin
      case (cfg_addr_e'(wr_addr))
        CFG_MC_TRIG: base_o[IDX_MC] <= new_base;
        CFG_SC_TRIG: base_o[IDX_SC] <= new_base;
        CFG_MC_MASK: mask_o[IDX_MC] <= NUM_TYPES'(wr_data);
        CFG_SC_MASK: mask_o[IDX_SC] <= NUM_TYPES'(wr_data);
        default:     ;
      endcase
    end
  end

endmodule

// File: rtl/ptc_err_counter.sv
module ptc_err_counter #(
  parameter int                   CNT_W     = 32,
  parameter int                   TYPE_W    = 5,
  parameter int                   NUM_TYPES = 32,
  parameter logic [CNT_W-1:0]     COUNTMAX  = 32'hC000_0000,
  parameter logic [CNT_W-1:0]     RST_BASE  = '0,
  parameter logic [NUM_TYPES-1:0] RST_MASK  = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 restart,
  input  logic                 count_en,
  input  logic                 ev_valid,
  input  logic [TYPE_W-1:0]    ev_type,
  input  logic [CNT_W-1:0]     base_i,
  input  logic [NUM_TYPES-1:0] cfg_mask_i,
  output logic [CNT_W-1:0]     cnt_o,
  output logic [CNT_W-1:0]     net_o,
  output logic                 hit_o
);

  logic [NUM_TYPES-1:0] act_mask_q;
  logic                 inc;

  assign inc   = count_en && ev_valid && act_mask_q[ev_type] && (cnt_o != '1);
  assign hit_o = cnt_o[CNT_W-1] & cnt_o[CNT_W-2];
  assign net_o = (cnt_o < base_i) ? COUNTMAX : (cnt_o - base_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o      <= RST_BASE;
      act_mask_q <= RST_MASK;
    end else if (restart) begin
      cnt_o      <= base_i;
      act_mask_q <= count_en ? cfg_mask_i : '0;
    end else begin
      if (!count_en) act_mask_q <= '0;
      if (inc)       cnt_o      <= cnt_o + 1'b1;
    end
  end

endmodule

// File: rtl/ptc_readout.sv
module ptc_readout
  import phyerr_trig_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          restart,
  input  logic                          rd_valid,
  input  logic                          rd_sel,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] raw_i,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] net_i,
  output logic                          rd_ack,
  output logic [CNT_W-1:0]              rd_raw,
  output logic [CNT_W-1:0]              rd_net,
  output logic [CNT_W-1:0]              rd_delta
);

  logic [NUM_CNT-1:0][CNT_W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ack   <= 1'b0;
      rd_raw   <= '0;
      rd_net   <= '0;
      rd_delta <= '0;
      prev_q   <= '0;
    end else begin
      rd_ack <= rd_valid;
      if (rd_valid) begin
        rd_raw   <= raw_i[rd_sel];
        rd_net   <= net_i[rd_sel];
        rd_delta <= net_i[rd_sel] - prev_q[rd_sel];
      end
      if (restart)       prev_q         <= '0;
      else if (rd_valid) prev_q[rd_sel] <= net_i[rd_sel];
    end
  end

endmodule

// File: rtl/phyerr_trig_cnt.sv
module phyerr_trig_cnt
  import phyerr_trig_pkg::*;
#(
  parameter int               CNT_W    = 32,
  parameter int               TYPE_W   = 5,
  parameter logic [CNT_W-1:0] COUNTMAX = 32'hC000_0000,
  parameter logic [CNT_W-1:0] MC_TRIG_DEF = 500,
  parameter logic [CNT_W-1:0] SC_TRIG_DEF = 200,
  parameter int               MC_CODE  = 17,
  parameter int               SC_CODE  = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [1:0]        wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              restart,
  input  logic              count_en,
  input  logic              ev_valid,
  input  logic [TYPE_W-1:0] ev_type,
  input  logic              rd_valid,
  input  logic              rd_sel,
  output logic              rd_ack,
  output logic [CNT_W-1:0]  rd_raw,
  output logic [CNT_W-1:0]  rd_net,
  output logic [CNT_W-1:0]  rd_delta,
  output logic              irq
);

  localparam int NUM_TYPES = 1 << TYPE_W;
  localparam logic [NUM_CNT-1:0][CNT_W-1:0] RST_BASE = {
    CNT_W'(base_calc(64'(SC_TRIG_DEF), 64'(COUNTMAX))),
    CNT_W'(base_calc(64'(MC_TRIG_DEF), 64'(COUNTMAX)))
  };
  localparam logic [NUM_CNT-1:0][NUM_TYPES-1:0] RST_MASK = {
    NUM_TYPES'(1) << SC_CODE,
    NUM_TYPES'(1) << MC_CODE
  };

  logic [NUM_CNT-1:0][CNT_W-1:0]     base_all;
  logic [NUM_CNT-1:0][NUM_TYPES-1:0] mask_all;
  logic [NUM_CNT-1:0][CNT_W-1:0]     cnt_all;
  logic [NUM_CNT-1:0][CNT_W-1:0]     net_all;
  logic [NUM_CNT-1:0]                hit_all;

  ptc_cfg_regs #(
    .CNT_W(CNT_W), .NUM_TYPES(NUM_TYPES), .COUNTMAX(COUNTMAX),
    .RST_BASE(RST_BASE), .RST_MASK(RST_MASK)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .base_o(base_all), .mask_o(mask_all)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    ptc_err_counter #(
      .CNT_W(CNT_W), .TYPE_W(TYPE_W), .NUM_TYPES(NUM_TYPES),
      .COUNTMAX(COUNTMAX), .RST_BASE(RST_BASE[g]), .RST_MASK(RST_MASK[g])
    ) u_counter (
      .clk(clk), .rst(rst), .restart(restart), .count_en(count_en),
      .ev_valid(ev_valid), .ev_type(ev_type),
      .base_i(base_all[g]), .cfg_mask_i(mask_all[g]),
      .cnt_o(cnt_all[g]), .net_o(net_all[g]), .hit_o(hit_all[g])
    );
  end

  ptc_readout #(.CNT_W(CNT_W)) u_rd (
    .clk(clk), .rst(rst), .restart(restart), .rd_valid(rd_valid),
    .rd_sel(rd_sel), .raw_i(cnt_all), .net_i(net_all),
    .rd_ack(rd_ack), .rd_raw(rd_raw), .rd_net(rd_net), .rd_delta(rd_delta)
  );

  // Sticky interrupt, released only by restart.
  always_ff @(posedge clk) begin
    if (rst)             irq <= 1'b0;
    else if (restart)    irq <= 1'b0;
    else if (|hit_all)   irq <= 1'b1;
  end

endmodule

// File: rtl/phyerr_trig_cnt_chk.sv
module phyerr_trig_cnt_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             restart,
  input logic             count_en,
  input logic             rd_valid,
  input logic             rd_ack,
  input logic             irq,
  input logic [CNT_W-1:0] cnt_mc,
  input logic [CNT_W-1:0] cnt_sc
);

  logic top_set;
  assign top_set = (&cnt_mc[CNT_W-1:CNT_W-2]) || (&cnt_sc[CNT_W-1:CNT_W-2]);

  AST_IRQ_HOLD:     assert property (@(posedge clk) disable iff (rst) irq && !restart |=> irq); // R4
  AST_IRQ_RELEASE:  assert property (@(posedge clk) disable iff (rst) restart |=> !irq); // R4
  AST_IRQ_ON_TOP:   assert property (@(posedge clk) disable iff (rst) top_set && !restart |=> irq); // R4
  AST_STEP_MC:      assert property (@(posedge clk) disable iff (rst) !restart |=> (cnt_mc == $past(cnt_mc)) || (cnt_mc == $past(cnt_mc) + 1'b1)); // R3
  AST_STEP_SC:      assert property (@(posedge clk) disable iff (rst) !restart |=> (cnt_sc == $past(cnt_sc)) || (cnt_sc == $past(cnt_sc) + 1'b1)); // R3
  AST_NO_WRAP:      assert property (@(posedge clk) disable iff (rst) !restart && (cnt_mc == '1) |=> cnt_mc == '1); // R3
  AST_FROZEN_OFF:   assert property (@(posedge clk) disable iff (rst) !restart && !count_en |=> $stable(cnt_mc) && $stable(cnt_sc)); // R9
  AST_RD_ACK:       assert property (@(posedge clk) disable iff (rst) rd_valid |=> rd_ack); // R5
  AST_RD_ACK_IDLE:  assert property (@(posedge clk) disable iff (rst) !rd_valid |=> !rd_ack); // R5

endmodule

bind phyerr_trig_cnt phyerr_trig_cnt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .restart(restart), .count_en(count_en),
  .rd_valid(rd_valid), .rd_ack(rd_ack), .irq(irq),
  .cnt_mc(cnt_all[0]), .cnt_sc(cnt_all[1])
);

// File: tb/test_phyerr_trig_cnt.sv
module test_phyerr_trig_cnt;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] CMAX       = 32'hC000_0000;
  localparam logic [31:0] SAT_CMAX   = 32'hFFFF_FFF0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 0, restart = 0, count_en = 1, ev_valid = 0, rd_valid = 0, rd_sel = 0;
  logic [1:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [4:0]  ev_type = 0;
  logic        rd_ack, irq, s_ack, s_irq;
  logic [31:0] rd_raw, rd_net, rd_delta, s_raw, s_net, s_delta;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phyerr_trig_cnt i_phyerr_trig_cnt (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .restart(restart), .count_en(count_en), .ev_valid(ev_valid), .ev_type(ev_type),
    .rd_valid(rd_valid), .rd_sel(rd_sel), .rd_ack(rd_ack), .rd_raw(rd_raw),
    .rd_net(rd_net), .rd_delta(rd_delta), .irq(irq)
  );

  // Second copy with a high ceiling, used only to reach saturation quickly.
  phyerr_trig_cnt #(.COUNTMAX(SAT_CMAX)) i_phyerr_trig_cnt_sat (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .restart(restart), .count_en(count_en), .ev_valid(ev_valid), .ev_type(ev_type),
    .rd_valid(rd_valid), .rd_sel(rd_sel), .rd_ack(s_ack), .rd_raw(s_raw),
    .rd_net(s_net), .rd_delta(s_delta), .irq(s_irq)
  );

  // Reference state
  logic [31:0] m_cnt [2];
  logic [31:0] m_base[2];
  logic [31:0] m_cfgm[2];
  logic [31:0] m_act [2];
  logic [31:0] m_prev[2];
  logic        m_irq;

  function automatic logic [31:0] base_f(input logic [31:0] trig);
    return (trig >= CMAX) ? 32'd0 : CMAX - trig;
  endfunction

  function automatic logic [31:0] net_f(input logic [31:0] raw, input logic [31:0] b);
    return (raw < b) ? CMAX : raw - b;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: sample expectations, let the edge pass, update model, check at negedge.
  task automatic cyc(input string tag);
    logic [31:0] e_raw, e_net, e_delta;
    logic        hit, was_rd, inc;
    int          s;
    s       = int'(rd_sel);
    was_rd  = rd_valid;
    e_raw   = m_cnt[s];
    e_net   = net_f(m_cnt[s], m_base[s]);
    e_delta = e_net - m_prev[s];
    hit     = (&m_cnt[0][31:30]) || (&m_cnt[1][31:30]);
    @(posedge clk);
    if (restart) m_irq = 1'b0; else if (hit) m_irq = 1'b1;
    if (restart) begin m_prev[0] = 0; m_prev[1] = 0; end
    else if (rd_valid) m_prev[s] = e_net;
    for (int i = 0; i < 2; i++) begin
      if (restart) begin
        m_cnt[i] = m_base[i];
        m_act[i] = count_en ? m_cfgm[i] : 32'd0;
      end else begin
        inc = count_en && ev_valid && m_act[i][ev_type] && (m_cnt[i] != 32'hFFFF_FFFF);
        if (!count_en) m_act[i] = 32'd0;
        if (inc) m_cnt[i] = m_cnt[i] + 1;
      end
    end
    if (wr_valid) begin
      case (wr_addr)
        2'd0: m_base[0] = base_f(wr_data);
        2'd1: m_base[1] = base_f(wr_data);
        2'd2: m_cfgm[0] = wr_data;
        default: m_cfgm[1] = wr_data;
      endcase
    end
    @(negedge clk);
    chk("R4 irq", {31'd0, irq}, {31'd0, m_irq});
    if (was_rd) begin
      chk({tag, " raw"},   rd_raw,   e_raw);
      chk({tag, " net"},   rd_net,   e_net);
      chk({tag, " delta"}, rd_delta, e_delta);
      chk("R5 ack", {31'd0, rd_ack}, 32'd1);
    end
    wr_valid = 0; restart = 0; ev_valid = 0; rd_valid = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input string tag);
    wr_valid = 1; wr_addr = a; wr_data = d; cyc(tag);
  endtask
  task automatic rs(input string tag);
    restart = 1; cyc(tag);
  endtask
  task automatic ev(input logic [4:0] t, input string tag);
    ev_valid = 1; ev_type = t; cyc(tag);
  endtask
  task automatic rd(input logic sel, input string tag);
    rd_valid = 1; rd_sel = sel; cyc(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    m_base[0] = base_f(500); m_base[1] = base_f(200);
    m_cfgm[0] = 32'h1 << 17; m_cfgm[1] = 32'h1 << 25;
    m_act[0]  = m_cfgm[0];   m_act[1]  = m_cfgm[1];
    m_cnt[0]  = m_base[0];   m_cnt[1]  = m_base[1];
    m_prev[0] = 0; m_prev[1] = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: reset bases
    chk("R1 reset irq", {31'd0, irq}, 32'd0);
    rd(0, "R1 reset mc");
    chk("R1 reset mc raw", rd_raw, CMAX - 500);
    rd(1, "R1 reset sc");
    chk("R1 reset sc raw", rd_raw, CMAX - 200);

    // R10/R8: new trigger applied at restart; R2 masking
    wr(2'd0, 32'd5, "R10 trig write");
    rd(0, "R10 net uses new base");
    rs("R8 restart");
    rd(0, "R8 reload");
    chk("R8 reload raw", rd_raw, CMAX - 5);
    ev(5'd25, "R2 foreign code");
    ev(5'd3, "R2 foreign code");
    rd(0, "R2 ignored");
    chk("R2 mc unchanged", rd_raw, CMAX - 5);
    for (int k = 0; k < 4; k++) ev(5'd17, "R2 count");
    cyc("R4 idle");
    chk("R4 below trigger", {31'd0, irq}, 32'd0);
    ev(5'd17, "R4 fifth");
    cyc("R4 idle");
    chk("R4 at trigger", {31'd0, irq}, 32'd1);
    repeat (3) cyc("R4 sticky");
    chk("R4 sticky", {31'd0, irq}, 32'd1);
    rd(0, "R5 read no clear");
    rd(0, "R5 read no clear");
    chk("R5 raw kept", rd_raw, CMAX);
    restart = 1; ev_valid = 1; ev_type = 5'd17; cyc("R8 restart wins");
    chk("R4 cleared", {31'd0, irq}, 32'd0);
    rd(0, "R8 event lost");
    chk("R8 event lost raw", rd_raw, CMAX - 5);

    // R7: delta between reads
    rd(1, "R7 first");
    ev(5'd25, "R7 ev"); ev(5'd25, "R7 ev"); ev(5'd25, "R7 ev");
    rd(1, "R7 second");
    chk("R7 delta 3", rd_delta, 32'd3);
    rs("R7 restart");
    rd(1, "R7 after restart");
    chk("R7 prev zeroed", rd_delta, 32'd0);

    // R1: trigger at or above ceiling; R6 negative net
    wr(2'd1, 32'hFFFF_FFFF, "R1 huge trig");
    rs("R1 restart");
    rd(1, "R1 base zero");
    chk("R1 base zero raw", rd_raw, 32'd0);
    wr(2'd1, 32'd10, "R6 trig");
    rd(1, "R6 negative");
    chk("R6 net ceiling", rd_net, CMAX);

    // R3: saturation on the high-ceiling copy
    wr(2'd0, 32'd0, "R3 trig0");
    rs("R3 restart");
    for (int k = 0; k < 20; k++) ev(5'd17, "R3 count");
    rd(0, "R3 read");
    chk("R3 saturated", s_raw, 32'hFFFF_FFFF);
    chk("R3 main unsat", rd_raw, CMAX + 20);

    // R9: disable
    wr(2'd0, 32'd100, "R9 trig");
    rs("R9 restart");
    count_en = 0;
    ev(5'd17, "R9 off"); ev(5'd17, "R9 off");
    count_en = 1;
    ev(5'd17, "R9 masks cleared"); ev(5'd17, "R9 masks cleared");
    rd(0, "R9 read");
    chk("R9 no counts", rd_raw, CMAX - 100);
    rs("R9 restart");
    ev(5'd17, "R9 resumed");
    rd(0, "R9 resumed");
    chk("R9 counting again", rd_raw, CMAX - 99);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 3) restart = 1;
      if (r >= 3 && r < 8) begin
        wr_valid = 1;
        wr_addr  = 2'($urandom % 4);
        if (wr_addr < 2) wr_data = ($urandom % 20 == 0) ? $urandom : 32'($urandom % 40);
        else             wr_data = $urandom | (32'h1 << (wr_addr == 2 ? 17 : 25));
      end
      if (r >= 8 && r < 10) count_en = ~count_en;
      if (!count_en && r > 90) count_en = 1;
      ev_valid = ($urandom % 3) != 0;
      case ($urandom % 3)
        0: ev_type = 5'd17;
        1: ev_type = 5'd25;
        default: ev_type = 5'($urandom);
      endcase
      rd_valid = ($urandom % 4) == 0;
      rd_sel   = 1'($urandom);
      cyc("R2 R6 R7 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule